// File: doc/BRIEF.md
# Bitfield Extract Unit

This execution unit pulls a bit field out of a 32-bit word for an integer pipeline. One control word carries both the field's start position and its width. The base word can be mirrored end to end before the field is taken. The field comes back either zero-extended or sign-extended. Defined results are produced in three edge cases: an empty field, a start position beyond the word, and a field that runs off the top of the word.

An operation is presented with `in_valid` high. Its result appears on `result` one clock later, with `out_valid` high. A cycle with `in_valid` low produces an idle output cycle and leaves `result` unchanged. The unit has no stall path, so a new operation can be accepted on every clock.

Top module: `bfx_unit`

## Requirements
- R1: The field start position is `ctrl[7:0]` and the field width is `ctrl[15:8]`, both unsigned. Bits `ctrl[31:16]` have no effect on the result.
- R2: In unsigned mode the result holds the width-bit field starting at the start position, zero-extended. Field bits that would lie above bit 31 of the base read as zero.
- R3: In signed mode the extracted field is sign-extended from its top bit (bit width-1 of the field).
- R4: In unsigned mode, a start position of 32 or more gives a result of zero.
- R5: In signed mode, a start position of 32 or more gives all ones when bit 31 of the base is set, and all zeros otherwise.
- R6: In signed mode, when start plus width is 32 or more, result bit 31 is replaced by base bit 31 and the other bits are kept. This rule is applied after R5. The sum is formed without wrap-around, so 255+255 counts as overflow.
- R7: A width of zero gives a result of zero in both modes. This rule overrides every other rule.
- R8: With `brev` high, the base is bit-mirrored (bit i moves to bit 31-i) before extraction. Every sign test in R3, R5 and R6 uses the mirrored value.
- R9: `out_valid` equals the previous cycle's `in_valid`. A synchronous reset clears `out_valid`.
- R10: `result` updates only in a cycle where `in_valid` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| base | input | 32 | Word the field is taken from |
| ctrl | input | 32 | Packed start position and width |
| brev | input | 1 | Mirror the base before extraction |
| is_signed | input | 1 | Sign-extend instead of zero-extend |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Extracted field |

## Verification
On every cycle, the embedded properties check:
- the one-cycle valid timing and the hold of `result` on idle cycles;
- the zero result for an empty field;
- the zero result for an unsigned out-of-range start;
- sign replication for a signed out-of-range start;
- the forced bit 31 on a signed overrun, with the base mirrored where `brev` asks.

Only the bench's scenarios can show the ordinary extraction values, the sign extension from the field's own top bit, and the fact that the upper control bits are ignored. They also show how the rules combine at the boundary start positions 0, 31, 32 and 255 and at widths that cross bit 31. A sweep against a bit-by-bit reference covers the remaining start positions.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] start;
  } bfx_ctrl_t;
endpackage

// File: rtl/bfx_reverse.sv
module bfx_reverse #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mirrored;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirrored[i] = din[DATA_W-1-i];
  end

  assign dout = en ? mirrored : din;
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8
) (
  input  logic [DATA_W-1:0]  word,
  input  logic [FIELD_W-1:0] start,
  input  logic [FIELD_W-1:0] width,
  input  logic               sign_mode,
  output logic [DATA_W-1:0]  field
);
  localparam int CMP_W = FIELD_W + 1;
  localparam logic [CMP_W-1:0] WORD_BITS = CMP_W'(DATA_W);

  logic [DATA_W-1:0]  shifted;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  raw;
  logic [DATA_W-1:0]  top_probe;
  logic [FIELD_W-1:0] top_idx;
  logic               full_width;

  assign full_width = {1'b0, width} >= WORD_BITS;
  assign shifted    = word >> start;
  assign mask       = full_width ? '1 : ~({DATA_W{1'b1}} << width);
  assign raw        = shifted & mask;
  assign top_idx    = width - FIELD_W'(1);
  assign top_probe  = raw >> top_idx;

  always_comb begin
    field = raw;
    if (sign_mode && !full_width && top_probe[0]) begin
      field = raw | ~mask;
    end
  end
endmodule

// File: rtl/bfx_edge.sv
module bfx_edge #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8
) (
  input  logic [DATA_W-1:0]  basic,
  input  logic               word_msb,
  input  logic [FIELD_W-1:0] start,
  input  logic [FIELD_W-1:0] width,
  input  logic               sign_mode,
  output logic [DATA_W-1:0]  fixed
);
  localparam int CMP_W = FIELD_W + 1;
  localparam logic [CMP_W-1:0] WORD_BITS = CMP_W'(DATA_W);

  logic [CMP_W-1:0] span_end;
  logic             start_past;
  logic             overrun;
  logic             empty;

  assign span_end   = {1'b0, start} + {1'b0, width};
  assign start_past = {1'b0, start} >= WORD_BITS;
  assign overrun    = span_end >= WORD_BITS;
  assign empty      = (width == '0);

  always_comb begin
    fixed = basic;
    if (sign_mode && start_past) fixed = {DATA_W{word_msb}};
    if (sign_mode && overrun)    fixed[DATA_W-1] = word_msb;
    if (empty)                   fixed = '0;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] ctrl,
  input  logic              brev,
  input  logic              is_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int CTRL_USED = 2 * FIELD_W;

  bfx_ctrl_t         c;
  logic              ctrl_unused;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] basic;
  logic [DATA_W-1:0] fixed;

  assign c           = ctrl[CTRL_USED-1:0];
  assign ctrl_unused = ^ctrl[DATA_W-1:CTRL_USED];

  bfx_reverse #(.DATA_W(DATA_W)) u_rev (
    .en(brev), .din(base), .dout(word)
  );

  bfx_extract #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_ext (
    .word(word), .start(c.start), .width(c.width),
    .sign_mode(is_signed), .field(basic)
  );

  bfx_edge #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_edge (
    .basic(basic), .word_msb(word[DATA_W-1]), .start(c.start),
    .width(c.width), .sign_mode(is_signed), .fixed(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= fixed;
    end
  end

  // Checks derived from the port values, not from the internal select logic.
  logic in_msb;
  assign in_msb = brev ? base[0] : base[DATA_W-1];

  a_r9_valid_set: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_clr: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl[15:8] == 8'd0) |=> (result == '0));
  a_r4_unsigned_far: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_signed && ctrl[7:0] >= 8'd32) |=> (result == '0));
  a_r5_signed_far: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_signed && ctrl[7:0] >= 8'd32 && ctrl[15:8] != 8'd0)
      |=> (result == {DATA_W{$past(in_msb)}}));
  a_r6_top_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_signed && ctrl[15:8] != 8'd0 &&
     ({1'b0, ctrl[7:0]} + {1'b0, ctrl[15:8]}) >= 9'd32)
      |=> (result[DATA_W-1] == $past(in_msb)));
endmodule

// File: tb/bfx_unit_test.sv
`timescale 1ns/1ps
module bfx_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] base = '0;
  logic [31:0] ctrl = '0;
  logic        brev = 1'b0;
  logic        is_signed = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bfx_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .ctrl(ctrl),
    .brev(brev), .is_signed(is_signed), .out_valid(out_valid), .result(result)
  );

  // Bit-by-bit reference built from the requirement text.
  function automatic logic [31:0] ref_model(input logic [31:0] b, input logic [31:0] cw,
                                            input logic rv, input logic sg);
    logic [31:0] w, r;
    int st, wd;
    st = int'(cw[7:0]);
    wd = int'(cw[15:8]);
    for (int i = 0; i < 32; i++) w[i] = rv ? b[31-i] : b[i];
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i < wd && st + i < 32) r[i] = w[st+i];
    if (sg && wd >= 1 && wd < 32 && r[wd-1])
      for (int i = 0; i < 32; i++) if (i >= wd) r[i] = 1'b1;
    if (sg && st >= 32) r = {32{w[31]}};
    if (sg && st + wd >= 32) r[31] = w[31];
    if (wd == 0) r = '0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] b, input logic [31:0] cw,
                     input logic rv, input logic sg, input logic [31:0] exp);
    @(negedge clk);
    base = b; ctrl = cw; brev = rv; is_signed = sg; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, result, exp);
  endtask

  task automatic t_reset();
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_unsigned();
    run("R2 plain", 32'hF0F0_1234, 32'h0000_0804, 0, 0, 32'h0000_0023);
    run("R2 overrun zero-fill", 32'hA000_0000, 32'h0000_081C, 0, 0, 32'h0000_000A);
    run("R2 start 31", 32'h8000_0000, 32'h0000_011F, 0, 0, 32'h0000_0001);
    run("R4 start 32", 32'hFFFF_FFFF, 32'h0000_0420, 0, 0, 32'h0);
    run("R4 start 255", 32'hFFFF_FFFF, 32'h0000_01FF, 0, 0, 32'h0);
  endtask

  task automatic t_signed();
    run("R3 negative field", 32'h0000_0F80, 32'h0000_0804, 0, 1, 32'hFFFF_FFF8);
    run("R3 positive field", 32'h0000_0780, 32'h0000_0804, 0, 1, 32'h0000_0078);
    run("R5 start 32 negative", 32'h8000_0001, 32'h0000_0420, 0, 1, 32'hFFFF_FFFF);
    run("R5 start 32 positive", 32'h7FFF_FFFF, 32'h0000_0420, 0, 1, 32'h0);
    run("R5 start 255 width 255", 32'h8000_0000, 32'h0000_FFFF, 0, 1, 32'hFFFF_FFFF);
    run("R6 overrun bit31", 32'hA000_0000, 32'h0000_081C, 0, 1, 32'h8000_000A);
    run("R6 start 31 width 1", 32'h8000_0000, 32'h0000_011F, 0, 1, 32'hFFFF_FFFF);
    run("R6 full width", 32'h1234_5678, 32'h0000_2000, 0, 1, 32'h1234_5678);
  endtask

  task automatic t_zero_width();
    run("R7 unsigned", 32'hFFFF_FFFF, 32'h0000_0004, 0, 0, 32'h0);
    run("R7 signed past end", 32'h8000_0000, 32'h0000_0028, 0, 1, 32'h0);
  endtask

  task automatic t_reverse();
    run("R8 unsigned", 32'h0000_0001, 32'h0000_011F, 1, 0, 32'h0000_0001);
    run("R8 signed replicate", 32'h0000_0001, 32'h0000_0420, 1, 1, 32'hFFFF_FFFF);
    run("R8 signed field", 32'h0000_00F0, 32'h0000_0418, 1, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl_upper();
    run("R1 upper bits ignored", 32'hF0F0_1234, 32'hFFFF_0804, 0, 0, 32'h0000_0023);
  endtask

  task automatic t_hold();
    run("R10 setup", 32'h0000_00AB, 32'h0000_0800, 0, 0, 32'h0000_00AB);
    @(negedge clk);
    base = 32'hFFFF_FFFF; ctrl = 32'h0000_2000;
    @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R10 hold", result, 32'h0000_00AB);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 40; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] cw;
        cw = {16'd0, 8'(5 + 3 * s % 30), 8'(s)};
        run("R2/R3/R6/R8 sweep", 32'h9C3A_5E61 ^ (32'(s) << 8), cw, m[1], m[0],
            ref_model(32'h9C3A_5E61 ^ (32'(s) << 8), cw, m[1], m[0]));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_unsigned();
    t_signed();
    t_zero_width();
    t_reverse();
    t_ctrl_upper();
    t_hold();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule